// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing front end of a 512-byte serial EEPROM. It runs on a fast system clock. Its SCL and SDA inputs have already been brought into that clock domain. From the edges of those lines it finds Start and Stop conditions and checks the device select byte. It takes in the word address and the data bytes, answers each accepted byte with an acknowledge, and shifts stored bytes out during reads. The engine does not drive SDA directly. It raises a single pull-low request, and pad logic outside the block turns that request into the open-drain drive.

The storage array and the nonvolatile write timer sit outside the block. Each received data byte leaves the engine as a one-cycle write strobe with its address and data. A Stop that follows at least one data byte raises a one-cycle commit pulse. The array then holds `busy` high until the write cycle is over. Reads use the address output together with a read-data input that has one cycle of latency, in the style of a block RAM. While `busy` is high the engine ignores Start conditions, so a master can keep sending the select byte until it gets an acknowledge back.

The select byte is laid out as follows. Bits 7..2 must equal the `DEV_SEL` parameter, which defaults to 6'b101000. Bit 1 supplies the ninth array address bit for writes and random reads. Bit 0 is the direction, where 1 means read. With `DEV_SEL` at its default, 0xA0 and 0xA2 select write with address bit 8 set to 0 and 1, and 0xA1 selects read.

Top module: `eep_i2c_slave`

## Requirements
- R1: While reset is high, and on the first cycle after reset falls, `sda_low` is 0, `mem_we` is 0 and `commit` is 0. After reset the address pointer is 0.
- R2: A select byte whose bits 7..2 equal `DEV_SEL` is acknowledged. Any other select byte gets no acknowledge. After a select byte that does not match, the engine drives no acknowledge and raises no write strobe until the next Start.
- R3: In a write, the word address byte and every data byte are acknowledged. Each data byte produces one `mem_we` pulse. The address of the first data byte is {select bit 1, word address}.
- R4: Each data byte in a write advances only the low 4 pointer bits, which wrap from 15 to 0. The upper 5 bits stay the same. A seventeenth byte therefore overwrites the location of the first byte.
- R5: A Stop that ends a write with at least one data byte raises `commit` for exactly one cycle. A Stop that comes with no data byte raises no `commit`.
- R6: While `busy` is 1, a Start is ignored, so the following select byte gets no acknowledge. Once `busy` returns to 0, the same select byte is acknowledged again.
- R7: A read whose select byte has bit 0 = 1 returns the byte at the pointer and then adds 1 to the full 9-bit pointer. The pointer is therefore one past the last location accessed, whether that access was a read or a write.
- R8: A random read works as follows. The master writes a word address with no data. It then issues a repeated Start with a read select byte, and the engine returns the byte at {select bit 1 of the write select byte, word address}.
- R9: After a master NACK on a read byte, the engine returns to idle. It drives SDA on no bit until the next Start.
- R10: The engine asserts `sda_low` only while SCL is low. It releases the line (`sda_low` = 0) on every bit where it is neither acknowledging nor sending a 0 read bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Synchronized serial clock line |
| sda | input | 1 | Synchronized serial data line (the resolved bus value) |
| busy | input | 1 | High while the array runs its internal write cycle |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_addr` |
| sda_low | output | 1 | 1 requests that the pad pull SDA low |
| mem_addr | output | 9 | Array address for reads and write strobes |
| mem_wdata | output | 8 | Data byte that goes with `mem_we` |
| mem_we | output | 1 | One-cycle strobe for each received data byte |
| commit | output | 1 | One-cycle pulse at a Stop after write data |

## Verification
The bench targets the following corner cases:

- **Page wrap.** A write runs past 16 bytes. A design that carries into the upper address bits would write outside the page and would leave the next current read at the wrong location.
- **Polling during a write cycle.** A select byte is sent while `busy` is high. An engine that honoured that Start would acknowledge too early. An engine that never recovers from ignoring it would stay silent after the write completes.
- **Pointer continuity.** Current reads follow writes and other reads. Random reads load the pointer, including the ninth address bit taken from the select byte. An off-by-one pointer, or a lost high bit, returns the wrong byte.
- **Recovery after ignored traffic.** Extra clocks follow a master NACK, and a data byte follows a select byte that did not match. An engine that keeps driving on those bits, or raises a write strobe, corrupts the bus or the array.
- **Commit timing.** A design that commits on a Stop with no data would start a spurious write cycle.

// File: rtl/eep_slave_pkg.sv
package eep_slave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_WADR,
    ST_WDAT,
    ST_RDAT
  } eng_state_t;
endpackage

// File: rtl/eep_line_events.sv
module eep_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  // A data edge while the clock stays high marks a bus condition.
  assign ev_start = scl & scl_q & sda_q & ~sda;
  assign ev_stop  = scl & scl_q & ~sda_q & sda;
  assign ev_rise  = scl & ~scl_q;
  assign ev_fall  = ~scl & scl_q;
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
  parameter int AW     = 9,
  parameter int PAGE_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_page,
  input  logic          inc_full,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (inc_page) begin
      ptr <= {ptr[AW-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
    end else if (inc_full) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
  parameter logic [5:0] DEV_SEL = 6'b101000,
  parameter int         AW      = 9,
  parameter int         PAGE_W  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl,
  input  logic          sda,
  input  logic          busy,
  input  logic [7:0]    mem_rdata,
  output logic          sda_low,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          commit
);
  import eep_slave_pkg::*;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              hi_bit, rd_dir, m_ack, wrote;
  logic              ev_start, ev_stop, ev_rise, ev_fall;
  logic [AW-1:0]     ptr;
  logic              rx_state, byte_end, ack_end, rd_load;
  logic              ptr_load, ptr_inc_page;

  eep_line_events u_ev (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  always_comb begin
    rx_state = (state == ST_SEL) || (state == ST_WADR) || (state == ST_WDAT);
    byte_end = ev_fall && rx_state && (cnt == CNT_BYTE);
    ack_end  = ev_fall && rx_state && (cnt == CNT_ACK);
    rd_load  = ev_fall && (cnt == CNT_ACK) &&
               (((state == ST_SEL) && rd_dir) || ((state == ST_RDAT) && m_ack));
    ptr_load     = byte_end && (state == ST_WADR);
    ptr_inc_page = byte_end && (state == ST_WDAT);
  end

  eep_addr_ptr #(.AW(AW), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst(rst),
    .load(ptr_load), .load_val({hi_bit, shreg}),
    .inc_page(ptr_inc_page), .inc_full(rd_load),
    .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      hi_bit    <= 1'b0;
      rd_dir    <= 1'b0;
      m_ack     <= 1'b0;
      wrote     <= 1'b0;
      sda_low   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      commit    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      commit <= 1'b0;
      if (ev_stop) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
        commit  <= wrote;
        wrote   <= 1'b0;
      end else if (ev_start) begin
        // An internal write cycle masks every new Start.
        state   <= busy ? ST_IDLE : ST_SEL;
        cnt     <= '0;
        sda_low <= 1'b0;
      end else if (ev_rise && (state != ST_IDLE)) begin
        if ((state != ST_RDAT) && (cnt < CNT_BYTE))
          shreg <= {shreg[BYTE_W-2:0], sda};
        if ((state == ST_RDAT) && (cnt == CNT_BYTE))
          m_ack <= ~sda;
        if (cnt != CNT_ACK)
          cnt <= cnt + 1'b1;
      end else if (ev_fall && (state != ST_IDLE)) begin
        if (state == ST_RDAT) begin
          if (cnt == CNT_ACK) begin
            if (m_ack) begin
              shreg   <= mem_rdata;
              sda_low <= ~mem_rdata[BYTE_W-1];
              cnt     <= '0;
            end else begin
              state   <= ST_IDLE;
              sda_low <= 1'b0;
            end
          end else if (cnt == CNT_BYTE) begin
            sda_low  <= 1'b0;
            mem_addr <= ptr;
          end else if (cnt != '0) begin
            sda_low <= ~shreg[BYTE_W-2];
            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
          end
        end else if (byte_end) begin
          case (state)
            ST_SEL: begin
              if (shreg[BYTE_W-1:2] == DEV_SEL) begin
                sda_low  <= 1'b1;
                hi_bit   <= shreg[1];
                rd_dir   <= shreg[0];
                mem_addr <= ptr;
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WADR: sda_low <= 1'b1;
            default: begin
              sda_low   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= ptr;
              mem_wdata <= shreg;
              wrote     <= 1'b1;
            end
          endcase
        end else if (ack_end) begin
          cnt <= '0;
          if (rd_load) begin
            state   <= ST_RDAT;
            shreg   <= mem_rdata;
            sda_low <= ~mem_rdata[BYTE_W-1];
          end else begin
            sda_low <= 1'b0;
            state   <= (state == ST_SEL) ? ST_WADR : ST_WDAT;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl,
  input logic sda,
  input logic busy,
  input logic sda_low,
  input logic mem_we,
  input logic commit
);
  // R6: no response at all while the array is busy
  p_silent_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_low);

  // R10: the pull-low request starts only while the clock is low
  p_drive_low_scl_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !scl);

  // R3: each write strobe coincides with the acknowledge of its byte
  p_we_acked_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> sda_low);

  p_we_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R5: commit is a single-cycle pulse caused by a Stop
  p_commit_stop_r5: assert property (@(posedge clk) disable iff (rst)
    commit |-> ($past(scl) && $past(sda)));

  p_commit_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);
endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
  .clk(clk), .rst(rst), .scl(scl), .sda(sda), .busy(busy),
  .sda_low(sda_low), .mem_we(mem_we), .commit(commit)
);

// File: tb/eep_i2c_slave_test.sv
module eep_i2c_slave_test;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       busy;
  logic [7:0] mem_rdata;
  logic       sda_low;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic       commit;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_low;

  eep_i2c_slave uut (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda_line), .busy(busy),
    .mem_rdata(mem_rdata), .sda_low(sda_low), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .commit(commit)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A ^ {a[8], 7'b0};
  endfunction

  // array model with one cycle of read latency
  logic [7:0] ram [512];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) ram[i] <= pat(i);
      mem_rdata <= '0;
    end else begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  // write-cycle timer model
  int bcnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; bcnt <= 0;
    end else if (commit) begin
      busy <= 1'b1; bcnt <= 300;
    end else if (bcnt > 1) begin
      bcnt <= bcnt - 1;
    end else begin
      busy <= 1'b0; bcnt <= 0;
    end
  end

  typedef struct { logic [8:0] a; logic [7:0] d; } wr_t;
  wr_t q[$];
  int vectors = 0, errs = 0;
  int mon_vec = 0, mon_err = 0, mon_commits = 0;
  logic [7:0] exp_mem [512];

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (!rst && commit) mon_commits++;
    if (!rst && mem_we) begin
      mon_vec++;
      if (q.size() == 0) begin
        mon_err++;
        $display("FAIL R3 unexpected write actual=%0h:%0h expected=none", mem_addr, mem_wdata);
      end else begin
        wr_t e;
        e = q.pop_front();
        if (mem_addr !== e.a || mem_wdata !== e.d) begin
          mon_err++;
          $display("FAIL R3 R4 write actual=%0h:%0h expected=%0h:%0h",
                   mem_addr, mem_wdata, e.a, e.d);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl = 1'b1; half(); sda_m = 1'b0; half(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half(); half();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
    end
    sda_m = 1'b1; half(); scl = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = (sda_line == 1'b0);
    repeat (H/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      half(); scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H/2) @(negedge clk);
      scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1;
    half(); scl = 1'b1; half(); scl = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    half();
  endtask

  task automatic cur_read(input int a, input string tag);
    bit ack; logic [7:0] b;
    bus_start();
    send_byte(8'hA1, ack);
    chk(ack, "R2 read select ack", ack, 1);
    recv_byte(1'b0, b);
    chk(b == exp_mem[a], tag, b, exp_mem[a]);
    bus_stop();
  endtask

  task automatic rand_read(input logic [8:0] a, input string tag);
    bit ack; logic [7:0] b;
    bus_start();
    send_byte({6'b101000, a[8], 1'b0}, ack);
    chk(ack, "R8 dummy write select ack", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R8 word address ack", ack, 1);
    bus_start();
    send_byte(8'hA1, ack);
    chk(ack, "R8 repeated start select ack", ack, 1);
    recv_byte(1'b0, b);
    chk(b == exp_mem[a], tag, b, exp_mem[a]);
  endtask

  initial begin
    repeat (600000) @(negedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_vec + 1, errs + mon_err);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < 512; i++) exp_mem[i] = pat(i);
    repeat (5) @(negedge clk);
    chk(sda_low == 1'b0 && mem_we == 1'b0 && commit == 1'b0, "R1 outputs in reset",
        {sda_low, mem_we, commit}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(sda_low == 1'b0 && mem_we == 1'b0 && commit == 1'b0, "R1 outputs after reset",
        {sda_low, mem_we, commit}, 0);

    // byte write to 0x135 (select bit 1 = 1)
    bus_start();
    send_byte(8'hA2, ack);
    chk(ack, "R2 matching select ack", ack, 1);
    send_byte(8'h35, ack);
    chk(ack, "R3 word address ack", ack, 1);
    q.push_back('{9'h135, 8'h11});
    exp_mem[9'h135] = 8'h11;
    send_byte(8'h11, ack);
    chk(ack, "R3 data ack", ack, 1);
    bus_stop();
    chk(mon_commits == 1, "R5 commit after write stop", mon_commits, 1);

    // acknowledge polling
    bus_start();
    send_byte(8'hA0, ack);
    chk(!ack, "R6 no ack while busy", ack, 0);
    bus_stop();
    wait_idle();
    bus_start();
    send_byte(8'hA0, ack);
    chk(ack, "R6 ack once write done", ack, 1);
    bus_stop();
    chk(mon_commits == 1, "R5 no commit without data", mon_commits, 1);

    // current reads continue after the write
    cur_read(9'h136, "R7 current read after write");
    cur_read(9'h137, "R7 current read after read");

    // page write of 18 bytes from 0x04C wraps inside the page
    bus_start();
    send_byte(8'hA0, ack);
    chk(ack, "R2 select ack page", ack, 1);
    send_byte(8'h4C, ack);
    chk(ack, "R3 page word address ack", ack, 1);
    for (int k = 0; k < 18; k++) begin
      logic [8:0] a;
      logic [7:0] d;
      a = 9'h040 | 9'((12 + k) % 16);
      d = 8'(8'h80 + k);
      q.push_back('{a, d});
      exp_mem[a] = d;
      send_byte(d, ack);
      chk(ack, "R3 page data ack", ack, 1);
    end
    bus_stop();
    chk(mon_commits == 2, "R5 commit after page write", mon_commits, 2);
    wait_idle();
    cur_read(9'h04E, "R4 pointer kept inside page");

    // random reads
    rand_read(9'h04C, "R4 R8 overwritten first location");
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R9 R10 line released after master nack", b, 8'hFF);
    bus_stop();
    rand_read(9'h110, "R8 random read with high bit");
    bus_stop();
    cur_read(9'h111, "R7 current read after random read");

    // select byte that does not match
    bus_start();
    send_byte(8'hB0, ack);
    chk(!ack, "R2 mismatch not acked", ack, 0);
    send_byte(8'h55, ack);
    chk(!ack, "R2 following byte ignored", ack, 0);
    bus_stop();
    chk(mon_commits == 2, "R2 R5 no commit after mismatch", mon_commits, 2);
    chk(q.size() == 0, "R3 every expected write seen", q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors + mon_vec, errs + mon_err);
    $finish;
  end
endmodule